// File: doc/BRIEF.md
# DDR3 Refresh Pull-In Scheduler

This block decides when a DDR3 controller issues REFRESH to a single rank. A free-running interval timer marks each average refresh period. When the rank carries traffic, the block asks for exactly one refresh per period. When the rank sits idle, it asks for refreshes ahead of schedule and keeps them as credit. Each later period that finds credit consumes one unit and sends no command, so that busy stretches lose no bandwidth to refresh.

Refreshes reach the command arbiter through a level request with a one-cycle acknowledge. An acknowledged refresh first pays off any period slots that are still owed. Only when nothing is owed does it add one unit of credit. After every acknowledge the block waits a recovery window before it raises another request. The current credit is visible on an output.

Top module: `ref_pullin_sched`

## Requirements
- R1: While rst_ni is low, ref_req_o is 0 and credit_o is 0. The interval timer and the owed-slot count are also cleared, so the first period ends TREFI_CYC cycles after reset is released.
- R2: The interval timer fires exactly once every TREFI_CYC cycles. While busy_i is held high with no credit, and each request is acknowledged at once, consecutive requests rise exactly TREFI_CYC cycles apart.
- R3: While busy_i is low, early refreshes are requested and acknowledged until credit_o reaches MAX_CREDIT (8). credit_o never exceeds MAX_CREDIT.
- R4: When a period ends with credit_o above zero, credit_o drops by one and no refresh is owed for that period. credit_o never decreases at any other time.
- R5: When a period ends with credit_o at zero, a refresh becomes owed. The request for it rises one cycle later at most, whatever the state of busy_i, unless a recovery window is running.
- R6: Once raised, ref_req_o stays high until the cycle in which ref_ack_i is seen high. An acknowledge that pays an owed slot leaves credit_o unchanged. An acknowledge when nothing is owed raises credit_o by one.
- R7: After an acknowledged refresh, ref_req_o stays low for at least TRFC_CYC+1 cycles, counting the acknowledge edge.
- R8: Periods that end while a refresh is still owed are counted, up to MAX_OWED. Each such period is paid by its own acknowledged refresh before any acknowledge can add credit, and credit_o is 0 whenever anything is owed.
- R9: While busy_i is high and nothing is owed, no new request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Rank has traffic; blocks early refreshes |
| ref_req_o | output | 1 | Refresh request toward the command arbiter |
| ref_ack_i | input | 1 | Arbiter has issued the requested refresh (sampled only while ref_req_o is high) |
| credit_o | output | $clog2(MAX_CREDIT+1) | Number of refreshes issued ahead of schedule |

## Verification
The state that is hardest to reach is a backlog of several owed periods. It needs a full credit bank drained by a long busy stretch, followed by requests the arbiter leaves unanswered across more than one timer period. The stimulus first fills credit with the rank idle and then holds busy_i high with immediate acknowledges until requests come at period spacing. It then withholds acknowledges for three periods and finally releases them. Only after every owed slot has been paid can credit grow again. A long randomized phase with busy bursts and random acknowledge delays then mixes ticks that land on, and next to, acknowledge edges.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;

  // counter width able to hold 0..max, never narrower than one bit
  function automatic int unsigned cnt_bits(int unsigned max_val);
    int unsigned n;
    n = $clog2(max_val + 1);
    return (n < 1) ? 1 : n;
  endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned TREFI_CYC = 7800
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned TW = ref_sched_pkg::cnt_bits(TREFI_CYC - 1);

  logic [TW-1:0] cnt_q;

  assign tick_o = (cnt_q == TW'(TREFI_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + TW'(1);
  end

endmodule

// File: rtl/ref_credit_ledger.sv
module ref_credit_ledger #(
  parameter int unsigned MAX_CREDIT = 8,
  parameter int unsigned MAX_OWED   = 15,
  localparam int unsigned CredW = ref_sched_pkg::cnt_bits(MAX_CREDIT),
  localparam int unsigned OwedW = ref_sched_pkg::cnt_bits(MAX_OWED)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             served_i,
  output logic [CredW-1:0] credit_o,
  output logic             owed_nz_o,
  output logic             room_o
);
  logic [CredW-1:0] credit_q, credit_d;
  logic [OwedW-1:0] owed_q, owed_d;

  // period end is applied first, then the served refresh
  always_comb begin
    credit_d = credit_q;
    owed_d   = owed_q;
    if (tick_i) begin
      if (credit_q != '0)                 credit_d = credit_q - CredW'(1);
      else if (owed_q != OwedW'(MAX_OWED)) owed_d  = owed_q + OwedW'(1);
    end
    if (served_i) begin
      if (owed_d != '0)                          owed_d   = owed_d - OwedW'(1);
      else if (credit_d != CredW'(MAX_CREDIT))   credit_d = credit_d + CredW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      credit_q <= '0;
      owed_q   <= '0;
    end else begin
      credit_q <= credit_d;
      owed_q   <= owed_d;
    end
  end

  assign credit_o  = credit_q;
  assign owed_nz_o = (owed_q != '0);
  assign room_o    = (credit_q != CredW'(MAX_CREDIT));

endmodule

// File: rtl/ref_req_ctrl.sv
module ref_req_ctrl #(
  parameter int unsigned TRFC_CYC = 208
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic ack_i,
  input  logic owed_nz_i,
  input  logic room_i,
  output logic req_o,
  output logic served_o
);
  logic req_q;
  logic hold_zero;
  logic raise;

  assign served_o = req_q & ack_i;

  generate
    if (TRFC_CYC == 0) begin : g_nohold
      assign hold_zero = 1'b1;
    end else begin : g_hold
      localparam int unsigned HW = ref_sched_pkg::cnt_bits(TRFC_CYC);
      logic [HW-1:0] hold_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             hold_q <= '0;
        else if (served_o)       hold_q <= HW'(TRFC_CYC);
        else if (hold_q != '0)   hold_q <= hold_q - HW'(1);
      end
      assign hold_zero = (hold_q == '0);
    end
  endgenerate

  // owed slots win; early refresh only with an idle rank and room in the bank
  assign raise = !req_q && hold_zero && (owed_nz_i || (!busy_i && room_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    req_q <= 1'b0;
    else if (req_q) req_q <= !ack_i;
    else            req_q <= raise;
  end

  assign req_o = req_q;

endmodule

// File: rtl/ref_pullin_sched.sv
module ref_pullin_sched #(
  parameter int unsigned TREFI_CYC  = 7800,
  parameter int unsigned TRFC_CYC   = 208,
  parameter int unsigned MAX_CREDIT = 8,
  parameter int unsigned MAX_OWED   = 15,
  localparam int unsigned CredW = ref_sched_pkg::cnt_bits(MAX_CREDIT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  output logic             ref_req_o,
  input  logic             ref_ack_i,
  output logic [CredW-1:0] credit_o
);
  logic tick;
  logic served;
  logic owed_nz;
  logic room;

  ref_interval_timer #(
    .TREFI_CYC(TREFI_CYC)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  ref_credit_ledger #(
    .MAX_CREDIT(MAX_CREDIT),
    .MAX_OWED  (MAX_OWED)
  ) u_ledger (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .served_i  (served),
    .credit_o  (credit_o),
    .owed_nz_o (owed_nz),
    .room_o    (room)
  );

  ref_req_ctrl #(
    .TRFC_CYC(TRFC_CYC)
  ) u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy_i),
    .ack_i     (ref_ack_i),
    .owed_nz_i (owed_nz),
    .room_i    (room),
    .req_o     (ref_req_o),
    .served_o  (served)
  );

endmodule

// File: rtl/ref_pullin_sched_chk.sv
module ref_pullin_sched_chk #(
  parameter int unsigned TRFC_CYC   = 208,
  parameter int unsigned MAX_CREDIT = 8,
  localparam int unsigned CredW = ref_sched_pkg::cnt_bits(MAX_CREDIT),
  localparam int unsigned HW    = ref_sched_pkg::cnt_bits(TRFC_CYC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             ref_req_o,
  input logic             ref_ack_i,
  input logic [CredW-1:0] credit_o,
  input logic             tick_i,
  input logic             owed_nz_i
);
  logic [HW-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     win_q <= '0;
    else if (ref_req_o && ref_ack_i) win_q <= HW'(TRFC_CYC);
    else if (win_q != '0)            win_q <= win_q - HW'(1);
  end

  a_r3_credit_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    credit_o <= CredW'(MAX_CREDIT));

  a_r4_no_drop_off_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> credit_o >= $past(credit_o));

  a_r4_tick_spends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && credit_o != '0 && !(ref_req_o && ref_ack_i)) |=> credit_o == $past(credit_o) - CredW'(1));

  a_r5_due_raised: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owed_nz_i && !ref_req_o && win_q == '0) |=> ref_req_o);

  a_r6_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && !ref_ack_i) |=> ref_req_o);

  a_r7_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q != '0) |-> !ref_req_o);

  a_r8_no_credit_while_owed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (credit_o != '0) |-> !owed_nz_i);

  a_r9_busy_no_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_req_o && busy_i && !owed_nz_i) |=> !ref_req_o);

endmodule

bind ref_pullin_sched ref_pullin_sched_chk #(
  .TRFC_CYC  (TRFC_CYC),
  .MAX_CREDIT(MAX_CREDIT)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_i    (busy_i),
  .ref_req_o (ref_req_o),
  .ref_ack_i (ref_ack_i),
  .credit_o  (credit_o),
  .tick_i    (tick),
  .owed_nz_i (owed_nz)
);

// File: tb/ref_pullin_sched_test.sv
module ref_pullin_sched_test;
  localparam int TREFI = 40;
  localparam int TRFC  = 4;
  localparam int MAXC  = 8;
  localparam int MAXO  = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy = 1'b0;
  logic       ack = 1'b0;
  logic       req;
  logic [3:0] credit;

  always #2 clk = ~clk;

  ref_pullin_sched #(
    .TREFI_CYC (TREFI),
    .TRFC_CYC  (TRFC),
    .MAX_CREDIT(MAXC),
    .MAX_OWED  (MAXO)
  ) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .busy_i    (busy),
    .ref_req_o (req),
    .ref_ack_i (ack),
    .credit_o  (credit)
  );

  int    checks = 0, errors = 0;
  bit    done = 0;
  string phase = "R1";

  // reference model state (value after the coming edge)
  int m_cnt = 0, m_credit = 0, m_owed = 0, m_hold = 0;
  bit m_req = 0;

  // observation state
  int cyc_no = 0, rises = 0, busy_rises_cr = 0, prev_rise = 0, last_gap = 0;
  int low_cnt = 0, max_credit = 0, min_gap = 1000000, last_serve = -1000;
  bit prev_req = 0;

  task automatic chk(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_step(bit b, bit a);
    bit tick  = (m_cnt == TREFI - 1);
    bit sv    = a && m_req;
    bit raise = !m_req && m_hold == 0 && (m_owed > 0 || (!b && m_credit < MAXC));
    int c = m_credit;
    int o = m_owed;
    m_cnt = tick ? 0 : m_cnt + 1;
    if (tick) begin
      if (c > 0) c--;
      else if (o < MAXO) o++;
    end
    if (sv) begin
      if (o > 0) o--;
      else if (c < MAXC) c++;
    end
    m_credit = c;
    m_owed   = o;
    if (sv) m_hold = TRFC;
    else if (m_hold > 0) m_hold--;
    m_req = m_req ? !sv : raise;
  endtask

  // mode 0: never ack, 1: ack at once, 2: random ack
  task automatic cyc(bit b, int mode);
    @(negedge clk);
    cyc_no++;
    chk({phase, " req"}, req === m_req, int'(req), int'(m_req));
    chk({phase, " credit"}, int'(credit) == m_credit, int'(credit), m_credit);
    if (int'(credit) > max_credit) max_credit = int'(credit);
    if (req && !prev_req) begin
      rises++;
      if (busy && credit != 0) busy_rises_cr++;
      last_gap  = cyc_no - prev_rise;
      prev_rise = cyc_no;
      if (cyc_no - last_serve < min_gap) min_gap = cyc_no - last_serve;
    end
    if (!req) low_cnt++;
    prev_req = req;
    busy = b;
    ack  = req && (mode == 1 || (mode == 2 && $urandom_range(0, 2) == 0));
    if (ack) last_serve = cyc_no;
    model_step(b, ack);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_val;
    seed_val = $urandom(32'd2417);

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 req in reset", req === 1'b0, int'(req), 0);
    chk("R1 credit in reset", credit == 4'd0, int'(credit), 0);
    @(negedge clk);
    rst_n = 1'b1;
    model_step(1'b0, 1'b0);

    // R3/R7: idle rank banks early refreshes
    phase = "R3 idle fill";
    max_credit = 0;
    repeat (300) cyc(1'b0, 1);
    chk("R3 credit reached cap", max_credit == MAXC, max_credit, MAXC);
    chk("R7 recovery gap", min_gap >= TRFC + 1, min_gap, TRFC + 1);

    // R4/R5/R9/R2: busy rank spends credit then requests on period
    phase = "R4 busy drain";
    rises = 0;
    busy_rises_cr = 0;
    repeat (10 * TREFI) cyc(1'b1, 1);
    chk("R9 no early refresh while busy", busy_rises_cr == 0, busy_rises_cr, 0);
    chk("R5 due request while busy", rises >= 2, rises, 2);
    chk("R2 period spacing", last_gap == TREFI, last_gap, TREFI);
    chk("R4 credit spent", credit == 4'd0, int'(credit), 0);

    // R6: unanswered due request is held across periods
    phase = "R6 hold";
    for (int i = 0; i < TREFI + 5 && !req; i++) cyc(1'b1, 0);
    low_cnt = 0;
    repeat (3 * TREFI) cyc(1'b1, 0);
    chk("R6 request held without ack", low_cnt == 0, low_cnt, 0);
    chk("R6 credit unchanged while owed", credit == 4'd0, int'(credit), 0);

    // R8: backlog of owed periods paid before any credit
    phase = "R8 backlog";
    repeat (2 * TREFI) cyc(1'b1, 1);
    chk("R8 no credit from paying owed slots", credit == 4'd0, int'(credit), 0);
    phase = "R8 repay idle";
    repeat (TREFI) cyc(1'b0, 1);

    // mixed random traffic and ack delays
    phase = "R6 random";
    for (int blk = 0; blk < 200; blk++) begin
      bit b = ($urandom_range(0, 3) != 0);
      int len = $urandom_range(2, 30);
      repeat (len) cyc(b, 2);
    end

    // R3: cap holds after long idle
    phase = "R3 cap";
    max_credit = 0;
    repeat (300) cyc(1'b0, 1);
    chk("R3 credit never above cap", max_credit <= MAXC, max_credit, MAXC);
    chk("R7 recovery gap overall", min_gap >= TRFC + 1, min_gap, TRFC + 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule